// File: doc/BRIEF.md
# Registered Integer ALU with Status Flags

This block is a single-issue integer arithmetic and logic unit of configurable width (8 to 64 bits). Each cycle it captures an opcode, a signed/unsigned mode bit and two operands into an input register stage. In the next cycle it writes one result and three status flags into an output register stage. The two register stages cover the whole path, so a new operation can be issued every clock and each result appears two rising edges after its inputs were presented.

A single carry-propagate adder does all of the add, subtract, increment, decrement and comparison work. Subtraction and comparison use the same adder: every bit of the second operand is inverted and the carry-in is forced high. A bit-sliced logic unit and a one-place shifter work beside the adder, and a result multiplexer picks which unit drives the output register. The mode bit changes only two things: how comparisons order the operands, and what the overflow flag reports.

Top module: `alu_slice_core`

## Requirements
- R1: Opcode 4'h0 gives a+b and opcode 4'h2 gives a+1, both modulo 2^W.
- R2: Opcode 4'h1 gives a-b and opcode 4'h3 gives a-1, both modulo 2^W.
- R3: Opcodes 4'h4, 4'h5, 4'h6 and 4'h7 give a&b, a|b, ~a and a^b respectively.
- R4: Opcode 4'h8 gives a shifted left by one place and opcode 4'h9 gives a shifted right by one place. Both fill the vacated bit with zero.
- R5: Opcodes 4'hA (a<b), 4'hB (a>b), 4'hC (a<=b), 4'hD (a>=b), 4'hE (a!=b) and 4'hF (a==b) return 1 or 0 in bit 0 with all upper bits zero. The operands are ordered as two's-complement numbers when signed_i=1 and as unsigned numbers when signed_i=0.
- R6: With signed_i=1, the overflow flag after opcodes 4'h0 to 4'h3 is set exactly when the true signed result lies outside the two's-complement range of W bits.
- R7: With signed_i=0, the overflow flag after opcodes 4'h0 and 4'h2 reports a carry out of W bits. After opcodes 4'h1 and 4'h3 it reports a borrow, meaning the true result is below zero.
- R8: The overflow flag is 0 after every logic, shift and comparison opcode (4'h4 to 4'hF).
- R9: The zero flag is 1 exactly when the registered result is all zeros. The negative flag equals the result's most significant bit.
- R10: Reset clears the result and all flags. The outputs for inputs presented before a rising edge appear after the following rising edge, so the result register updates one cycle after the operand register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| signed_i | input | 1 | 1 = signed interpretation, 0 = unsigned |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| result_o | output | W | Registered result |
| ovf_o | output | 1 | Overflow / carry / borrow flag |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Most significant bit of result |

## Verification
The assertions take every input to be a known 0 or 1 at each rising edge and depend on no ordering between operations, because every opcode is legal and the unit holds no state besides its two register stages. They compare each output register against the operand register of the previous cycle, so they need no reset-time history beyond one cycle. The stimulus drives fully defined values away from the clock edge. It draws opcodes across all sixteen codes and both modes, and draws operands from a mix of uniform values and the range edges (zero, all ones, the largest positive value, the most negative value). This is where carry, borrow and signed overflow change.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'h0,
        OP_SUB = 4'h1,
        OP_INC = 4'h2,
        OP_DEC = 4'h3,
        OP_AND = 4'h4,
        OP_OR  = 4'h5,
        OP_NOT = 4'h6,
        OP_XOR = 4'h7,
        OP_SHL = 4'h8,
        OP_SHR = 4'h9,
        OP_LT  = 4'hA,
        OP_GT  = 4'hB,
        OP_LE  = 4'hC,
        OP_GE  = 4'hD,
        OP_NE  = 4'hE,
        OP_EQ  = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_NOT = 2'd2,
        LG_XOR = 2'd3
    } logic_fn_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         inv_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         sovf_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] y_eff;

    always_comb begin
        y_eff            = y_i ^ {W{inv_i}};
        {cout_o, sum_o}  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, cin_i};
        sovf_o           = (x_i[MSB] == y_eff[MSB]) && (sum_o[MSB] != x_i[MSB]);
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_slice_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_fn_e    fn_i,
    output logic [W-1:0] y_o
);
    for (genvar k = 0; k < W; k++) begin : g_slice
        always_comb begin
            unique case (fn_i)
                LG_AND:  y_o[k] = a_i[k] & b_i[k];
                LG_OR:   y_o[k] = a_i[k] | b_i[k];
                LG_NOT:  y_o[k] = ~a_i[k];
                default: y_o[k] = a_i[k] ^ b_i[k];
            endcase
        end
    end
endmodule

// File: rtl/alu_shift1.sv
module alu_shift1 #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic         right_i,
    output logic [W-1:0] y_o
);
    localparam int MSB = W - 1;

    always_comb begin
        if (right_i) y_o = {1'b0, a_i[MSB:1]};
        else         y_o = {a_i[MSB-1:0], 1'b0};
    end
endmodule

// File: rtl/alu_slice_core.sv
module alu_slice_core
    import alu_slice_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic         signed_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] result_o,
    output logic         ovf_o,
    output logic         zero_o,
    output logic         neg_o
);
    localparam int MSB = W - 1;

    typedef struct packed {
        alu_op_e      op;
        logic         sgn;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } opnd_t;

    typedef struct packed {
        logic [W-1:0] res;
        logic         ovf;
        logic         z;
        logic         n;
    } outr_t;

    opnd_t opnd_d, opnd_q;
    outr_t outr_d, outr_q;

    logic [W-1:0] add_y, add_sum, lg_y, sh_y;
    logic         add_inv, add_cin, add_cout, add_sovf;
    logic         lt, eq, is_cmp;
    logic_fn_e    lg_fn;

    alu_addsub #(.W(W)) i_addsub (
        .x_i   (opnd_q.a),
        .y_i   (add_y),
        .inv_i (add_inv),
        .cin_i (add_cin),
        .sum_o (add_sum),
        .cout_o(add_cout),
        .sovf_o(add_sovf)
    );

    alu_bitwise #(.W(W)) i_bitwise (
        .a_i (opnd_q.a),
        .b_i (opnd_q.b),
        .fn_i(lg_fn),
        .y_o (lg_y)
    );

    alu_shift1 #(.W(W)) i_shift (
        .a_i    (opnd_q.a),
        .right_i(opnd_q.op == OP_SHR),
        .y_o    (sh_y)
    );

    always_comb begin
        opnd_d.op  = alu_op_e'(op_i);
        opnd_d.sgn = signed_i;
        opnd_d.a   = a_i;
        opnd_d.b   = b_i;

        lg_fn = logic_fn_e'(opnd_q.op[1:0]);

        unique case (opnd_q.op)
            OP_ADD:  begin add_y = opnd_q.b;   add_inv = 1'b0; add_cin = 1'b0; end
            OP_INC:  begin add_y = '0;         add_inv = 1'b0; add_cin = 1'b1; end
            OP_DEC:  begin add_y = '0;         add_inv = 1'b1; add_cin = 1'b0; end
            default: begin add_y = opnd_q.b;   add_inv = 1'b1; add_cin = 1'b1; end
        endcase

        eq     = (add_sum == '0);
        lt     = opnd_q.sgn ? (add_sum[MSB] ^ add_sovf) : ~add_cout;
        is_cmp = (opnd_q.op >= OP_LT);

        outr_d.res = '0;
        outr_d.ovf = 1'b0;
        unique case (opnd_q.op)
            OP_ADD, OP_INC: begin
                outr_d.res = add_sum;
                outr_d.ovf = opnd_q.sgn ? add_sovf : add_cout;
            end
            OP_SUB, OP_DEC: begin
                outr_d.res = add_sum;
                outr_d.ovf = opnd_q.sgn ? add_sovf : ~add_cout;
            end
            OP_AND, OP_OR, OP_NOT, OP_XOR: outr_d.res = lg_y;
            OP_SHL, OP_SHR:                outr_d.res = sh_y;
            OP_LT:   outr_d.res[0] = lt;
            OP_GT:   outr_d.res[0] = ~lt & ~eq;
            OP_LE:   outr_d.res[0] = lt | eq;
            OP_GE:   outr_d.res[0] = ~lt;
            OP_NE:   outr_d.res[0] = ~eq;
            default: outr_d.res[0] = eq;
        endcase
        outr_d.z = (outr_d.res == '0);
        outr_d.n = outr_d.res[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q <= '0;
            outr_q <= '0;
        end else begin
            opnd_q <= opnd_d;
            outr_q <= outr_d;
        end
    end

    assign result_o = outr_q.res;
    assign ovf_o    = outr_q.ovf;
    assign zero_o   = outr_q.z;
    assign neg_o    = outr_q.n;

    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_q.op == OP_ADD |=> result_o == $past(opnd_q.a + opnd_q.b)); // R1
    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_q.op == OP_SUB |=> result_o == $past(opnd_q.a - opnd_q.b)); // R2
    AST_SHL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_q.op == OP_SHL |=> result_o == $past(opnd_q.a << 1)); // R4
    AST_CMP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> result_o[MSB:1] == '0); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_q.op >= OP_AND |=> !ovf_o); // R8
    AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_q.op == OP_XOR) |=> result_o == $past(opnd_q.a ^ opnd_q.b)); // R10
endmodule

// File: tb/test_alu_slice_core.sv
module test_alu_slice_core;
    localparam int W = 16;
    localparam longint SMAX = (64'sd1 <<< (W - 1)) - 1;
    localparam longint SMIN = -(64'sd1 <<< (W - 1));
    localparam longint UMAX = (64'sd1 <<< W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op_i = '0;
    logic         signed_i = 1'b0;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic [W-1:0] result_o;
    logic         ovf_o, zero_o, neg_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu_slice_core #(.W(W)) i_alu_slice_core (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .signed_i(signed_i),
        .a_i(a_i), .b_i(b_i), .result_o(result_o), .ovf_o(ovf_o),
        .zero_o(zero_o), .neg_o(neg_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [3:0] op, input logic sg,
                                  input logic [W-1:0] a, input logic [W-1:0] b,
                                  output logic [W-1:0] r, output logic v);
        longint sa, sb, t;
        sa = sg ? longint'($signed(a)) : longint'(a);
        sb = sg ? longint'($signed(b)) : longint'(b);
        r = '0; v = 1'b0; t = 0;
        case (op)
            4'h0: t = sa + sb;
            4'h1: t = sa - sb;
            4'h2: t = sa + 1;
            4'h3: t = sa - 1;
            4'h4: r = a & b;
            4'h5: r = a | b;
            4'h6: r = ~a;
            4'h7: r = a ^ b;
            4'h8: r = a << 1;
            4'h9: r = a >> 1;
            4'hA: r = W'(sa < sb);
            4'hB: r = W'(sa > sb);
            4'hC: r = W'(sa <= sb);
            4'hD: r = W'(sa >= sb);
            4'hE: r = W'(sa != sb);
            default: r = W'(sa == sb);
        endcase
        if (op <= 4'h3) begin
            r = t[W-1:0];
            v = sg ? (t > SMAX || t < SMIN) : (t > UMAX || t < 0);
        end
    endfunction

    task automatic run(input logic [3:0] op, input logic sg, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] er;
        logic ev;
        string rt, vt;
        @(negedge clk);
        op_i = op; signed_i = sg; a_i = a; b_i = b;
        @(negedge clk);
        @(negedge clk);
        model(op, sg, a, b, er, ev);
        if (op <= 4'h2 && op != 4'h1) rt = "R1 add/inc";
        else if (op <= 4'h3)          rt = "R2 sub/dec";
        else if (op <= 4'h7)          rt = "R3 logic";
        else if (op <= 4'h9)          rt = "R4 shift";
        else                          rt = "R5 compare";
        if (op >= 4'h4)   vt = "R8 ovf clear";
        else if (sg)      vt = "R6 signed ovf";
        else              vt = "R7 carry/borrow";
        check(result_o === er, rt, longint'(result_o), longint'(er));
        check(ovf_o === ev, vt, longint'(ovf_o), longint'(ev));
        check(zero_o === (er == '0), "R9 zero", longint'(zero_o), longint'(er == '0));
        check(neg_o === er[W-1], "R9 neg", longint'(neg_o), longint'(er[W-1]));
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom_range(0, 5))
            0: return '0;
            1: return '1;
            2: return {1'b0, {(W-1){1'b1}}};
            3: return {1'b1, {(W-1){1'b0}}};
            default: return W'($urandom);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R10: reset state
        check(result_o === '0 && !ovf_o && !zero_o && !neg_o, "R10 reset", longint'(result_o), 0);
        rst_n = 1'b1;
        // R10: latency, result register changes one cycle after operand register
        @(negedge clk);
        op_i = 4'h0; signed_i = 1'b0; a_i = 16'd5; b_i = 16'd7;
        @(negedge clk);
        check(result_o === '0, "R10 not yet updated", longint'(result_o), 0);
        @(negedge clk);
        check(result_o === 16'd12, "R10 updated", longint'(result_o), 12);

        // directed corners
        run(4'h0, 1'b1, 16'h7FFF, 16'h0001);   // R6
        run(4'h0, 1'b0, 16'hFFFF, 16'h0001);   // R7 carry, R9 zero
        run(4'h1, 1'b1, 16'h8000, 16'h0001);   // R6
        run(4'h1, 1'b0, 16'h0000, 16'h0001);   // R7 borrow
        run(4'h2, 1'b1, 16'h7FFF, 16'h0000);   // R1 inc ovf
        run(4'h3, 1'b0, 16'h0000, 16'h0000);   // R2 dec borrow
        run(4'h3, 1'b1, 16'h8000, 16'h0000);   // R6 dec
        run(4'hA, 1'b1, 16'hFFFF, 16'h0001);   // R5 signed -1<1
        run(4'hA, 1'b0, 16'hFFFF, 16'h0001);   // R5 unsigned
        run(4'hB, 1'b1, 16'h7FFF, 16'h8000);   // R5
        run(4'hF, 1'b0, 16'h1234, 16'h1234);   // R5 eq
        run(4'hE, 1'b0, 16'h1234, 16'h1234);   // R5 ne
        run(4'h8, 1'b0, 16'h8001, 16'h0000);   // R4
        run(4'h9, 1'b0, 16'h8001, 16'h0000);   // R4
        run(4'h6, 1'b0, 16'h0F0F, 16'h0000);   // R3

        for (int i = 0; i < 400; i++)
            run(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), pick(), pick());

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule